// File: doc/BRIEF.md
# Programmable Audio Master Clock Generator

This block takes a fast audio source clock and derives two slower clocks from it: an audio master clock and a frame-rate clock. Two 6-bit ratio fields set the division. The master clock runs at source/(DIV+1). The frame clock runs at source/(32·(FS+1)). The master-clock-to-frame ratio is therefore 32·(FS+1)/(DIV+1), which covers everything from 64 up to 1536. For example, DIV=7 with FS=63 gives 256, DIV=0 with FS=47 gives 1536, and DIV=7 with FS=15 gives 64.

A single-cycle start strobe launches the generator and a separate stop strobe halts it. The generator runs only while the enclosing audio port is the clock master; in slave mode the clocks come from outside and a start strobe is refused. A mode input, captured at start, picks the output:
- When it is set, the divided master clock appears on the master-clock pin.
- When it is clear, no master clock is produced and the source clock itself is gated onto the bit-clock pin.

Ratio changes reach a divider only when that divider's counter wraps. A stop never cuts a high phase short, so no runt pulse is produced.

Top module: `audclk_gen`

## Requirements
- R1: While reset is held and after it is released, with no start strobe seen, `mck_o`, `bck_o` and `fs_o` are low.
- R2: After an accepted start in master-clock mode (`mck_mode`=1) with DIV≥1:
  - The clock edge that samples the start is cycle 0.
  - Each period of `mck_o` lasts DIV+1 source cycles and is high for the first ceil((DIV+1)/2) of them, starting in cycle 0.
  - Odd divide values are therefore high for one source period more than they are low.
- R3: With DIV=0 in master-clock mode, `mck_o` is high in cycle 0 and afterwards follows the source clock (high while `src_clk` is high, low while it is low).
- R4: While running, `fs_o` has a period of 32·(FS+1) source cycles and is high for the first half of each period, starting in cycle 0. One frame therefore holds 32·(FS+1)/(DIV+1) master-clock rising edges: 256 for DIV=7/FS=63, 1536 for DIV=0/FS=47, and 64 for DIV=7/FS=15.
- R5: The mode is captured at start; changing `mck_mode` while running has no effect.
  - Mode 1: `bck_o` stays low.
  - Mode 0: `mck_o` stays low, and from cycle 1 on `bck_o` follows the source clock.
- R6: A new DIV value presented while running is used only from the next wrap of the master-clock counter. The period in progress completes with the old value.
- R7: On a stop strobe in master-clock mode:
  - If `mck_o` is in a high phase, that high phase runs to its normal end, after which `mck_o` stays low.
  - If `mck_o` is in a low phase, the generator stops at that edge and no further high phase begins.
  - In both cases `fs_o` is low once the generator has stopped.
- R8: A start strobe is ignored in each of these cases:
  - `is_master` is low;
  - the stop strobe is high in the same cycle (stop wins);
  - the generator is already running, so no restart and no early reload takes place.
- R9: In bit-clock mode, a stop strobe lets the `bck_o` pulse that begins at the sampling edge complete, after which `bck_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_clk | input | 1 | Fast audio source clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| is_master | input | 1 | High when the audio port is the clock master; start is refused otherwise |
| clk_on | input | 1 | Single-cycle start strobe |
| clk_off | input | 1 | Single-cycle stop strobe; wins over `clk_on` |
| mck_mode | input | 1 | 1: generate master clock on `mck_o`; 0: pass source clock to `bck_o`; captured at start |
| mck_div | input | DIV_W (6) | DIV: master clock = source/(DIV+1) |
| fs_div | input | FS_W (6) | FS: frame rate = source/(32·(FS+1)) |
| mck_o | output | 1 | Master-clock pin |
| bck_o | output | 1 | Bit-clock pin (source clock pass-through in mode 0) |
| fs_o | output | 1 | Frame-rate clock, 50% duty |

## Verification
The ratio table walks seven settings through a full frame each, comparing both clock phases every cycle:
- The three example settings (256, 1536 and 64 master-clock edges per frame) separate a correct two-stage division from one that folds the 32× slot factor into the wrong divider.
- An odd divide of 5 and a divide of 3 separate the ceil-based high phase from a floor-based one.
- DIV=0 is the only case where the low-phase sample of `mck_o` differs from the high-phase sample, which distinguishes a real source pass-through from a registered level.

The directed cases issue the stop strobe once inside a high phase and once inside a low phase; together they tell apart stopping at once, stopping only after the high phase, and running on into a fresh pulse. A ratio change combined with a start strobe in mid-period distinguishes reload-at-wrap from both immediate reload and restart.

// File: rtl/acg_pkg.sv
package acg_pkg;
   // Output routing captured at start
   typedef enum logic {
      ROUTE_BCK_PASS = 1'b0,
      ROUTE_MCK_GEN  = 1'b1
   } route_e;

   // log2 of the fixed slot factor between frame and source divider
   localparam int unsigned SLOT_SHIFT_DEF = 5;
endpackage

// File: rtl/acg_div.sv
// Reloadable ratio divider: period LIM+1 cycles, high for the first ceil((LIM+1)/2).
module acg_div #(
   parameter int unsigned W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         start,
   input  logic         run,
   input  logic         halt,
   input  logic [W-1:0] lim_in,
   output logic         q,
   output logic         q_nxt,
   output logic         wrap,
   output logic [W-1:0] lim,
   output logic         lim_zero
);
   logic [W-1:0] cnt;
   logic [W:0]   cnt_inc;
   logic [W:0]   hi_len;
   logic         stay_hi;

   always_comb begin
      cnt_inc  = {1'b0, cnt} + (W+1)'(1);
      hi_len   = ({1'b0, lim} + (W+1)'(2)) >> 1;
      stay_hi  = cnt_inc < hi_len;
      wrap     = run && (cnt == lim);
      lim_zero = (lim == '0);
      q_nxt    = start | (run & (wrap | stay_hi));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         lim <= '0;
         q   <= 1'b0;
      end else if (start) begin
         cnt <= '0;
         lim <= lim_in;
         q   <= 1'b1;
      end else if (run && !halt) begin
         if (wrap) begin
            cnt <= '0;
            lim <= lim_in;
            q   <= 1'b1;
         end else begin
            cnt <= cnt_inc[W-1:0];
            q   <= stay_hi;
         end
      end else begin
         cnt <= '0;
         q   <= 1'b0;
      end
   end
endmodule

// File: rtl/acg_ctrl.sv
// Start/stop sequencing; a stop waits for the end of a master-clock high phase.
module acg_ctrl
   import acg_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   is_master,
   input  logic   on_stb,
   input  logic   off_stb,
   input  logic   mode_in,
   input  logic   mck_q,
   input  logic   mck_q_nxt,
   input  logic   mck_lim_zero,
   output logic   run_q,
   output route_e mode_q,
   output logic   start,
   output logic   halt
);
   logic pend_q;
   logic stop_req;

   always_comb begin
      start    = on_stb & is_master & ~off_stb & ~run_q;
      stop_req = run_q & (off_stb | pend_q);
      halt     = stop_req & ((mode_q == ROUTE_BCK_PASS) | mck_lim_zero
                             | ~mck_q | ~mck_q_nxt);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
         mode_q <= ROUTE_BCK_PASS;
      end else if (start) begin
         run_q  <= 1'b1;
         pend_q <= 1'b0;
         mode_q <= route_e'(mode_in);
      end else if (halt) begin
         run_q  <= 1'b0;
         pend_q <= 1'b0;
      end else if (stop_req) begin
         pend_q <= 1'b1;
      end
   end
endmodule

// File: rtl/acg_clk_mux.sv
// Glitch-free source-clock select: select flop updates while the clock is low.
module acg_clk_mux (
   input  logic clk,
   input  logic rst_n,
   input  logic sel_d,
   input  logic lvl,
   output logic o
);
   logic sel_q;

   always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= 1'b0;
      else        sel_q <= sel_d;
   end

   assign o = sel_q ? clk : lvl;
endmodule

// File: rtl/audclk_gen.sv
module audclk_gen
   import acg_pkg::*;
#(
   parameter int unsigned DIV_W      = 6,
   parameter int unsigned FS_W       = 6,
   parameter int unsigned SLOT_SHIFT = SLOT_SHIFT_DEF
) (
   input  logic             src_clk,
   input  logic             rst_n,
   input  logic             is_master,
   input  logic             clk_on,
   input  logic             clk_off,
   input  logic             mck_mode,
   input  logic [DIV_W-1:0] mck_div,
   input  logic [FS_W-1:0]  fs_div,
   output logic             mck_o,
   output logic             bck_o,
   output logic             fs_o
);
   localparam int unsigned FRM_W = FS_W + SLOT_SHIFT;

   if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div_w
      $error("audclk_gen: DIV_W must be 1..16");
   end
   if (FS_W < 1 || FRM_W > 24) begin : g_bad_fs_w
      $error("audclk_gen: FS_W + SLOT_SHIFT must be 1..24");
   end

   logic             run_q, start, halt;
   route_e           mode_q;
   logic             mck_q, mck_q_nxt, mck_wrap, mck_lim_zero;
   logic [DIV_W-1:0] mck_lim;
   logic             frm_unused_nxt, frm_unused_wrap, frm_unused_zero;
   logic [FRM_W-1:0] frm_unused_lim;
   logic [FRM_W-1:0] frm_lim_in;
   logic             mck_sel, bck_sel, mck_lvl;

   assign frm_lim_in = {fs_div, {SLOT_SHIFT{1'b1}}};

   acg_ctrl u_ctrl (
      .clk          (src_clk),
      .rst_n        (rst_n),
      .is_master    (is_master),
      .on_stb       (clk_on),
      .off_stb      (clk_off),
      .mode_in      (mck_mode),
      .mck_q        (mck_q),
      .mck_q_nxt    (mck_q_nxt),
      .mck_lim_zero (mck_lim_zero),
      .run_q        (run_q),
      .mode_q       (mode_q),
      .start        (start),
      .halt         (halt)
   );

   acg_div #(.W(DIV_W)) u_mck_div (
      .clk      (src_clk),
      .rst_n    (rst_n),
      .start    (start),
      .run      (run_q),
      .halt     (halt),
      .lim_in   (mck_div),
      .q        (mck_q),
      .q_nxt    (mck_q_nxt),
      .wrap     (mck_wrap),
      .lim      (mck_lim),
      .lim_zero (mck_lim_zero)
   );

   acg_div #(.W(FRM_W)) u_frm_div (
      .clk      (src_clk),
      .rst_n    (rst_n),
      .start    (start),
      .run      (run_q),
      .halt     (halt),
      .lim_in   (frm_lim_in),
      .q        (fs_o),
      .q_nxt    (frm_unused_nxt),
      .wrap     (frm_unused_wrap),
      .lim      (frm_unused_lim),
      .lim_zero (frm_unused_zero)
   );

   assign mck_sel = run_q & (mode_q == ROUTE_MCK_GEN) & mck_lim_zero;
   assign mck_lvl = mck_q & (mode_q == ROUTE_MCK_GEN);
   assign bck_sel = run_q & (mode_q == ROUTE_BCK_PASS);

   acg_clk_mux u_mck_mux (
      .clk   (src_clk),
      .rst_n (rst_n),
      .sel_d (mck_sel),
      .lvl   (mck_lvl),
      .o     (mck_o)
   );

   acg_clk_mux u_bck_mux (
      .clk   (src_clk),
      .rst_n (rst_n),
      .sel_d (bck_sel),
      .lvl   (1'b0),
      .o     (bck_o)
   );
endmodule

// File: rtl/acg_checker.sv
module acg_checker #(
   parameter int unsigned W = 6
) (
   input logic         clk,
   input logic         rst_n,
   input logic         is_master,
   input logic         clk_off,
   input logic         run_q,
   input logic         mode_gen,
   input logic         mck_q,
   input logic         mck_wrap,
   input logic [W-1:0] mck_lim,
   input logic         mck_o
);
   AST_START_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(run_q) |-> mck_q);  // R2
   AST_PASS_NO_MCK: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_gen |-> !mck_o);  // R5
   AST_RELOAD_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !mck_wrap) |=> $stable(mck_lim));  // R6
   AST_STOP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(run_q) |-> !mck_q);  // R7
   AST_SLAVE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && !is_master) |=> !run_q);  // R8
   AST_OFF_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_q && clk_off) |=> !run_q);  // R8
endmodule

bind audclk_gen acg_checker #(.W(DIV_W)) u_chk (
   .clk       (src_clk),
   .rst_n     (rst_n),
   .is_master (is_master),
   .clk_off   (clk_off),
   .run_q     (run_q),
   .mode_gen  (mode_q == acg_pkg::ROUTE_MCK_GEN),
   .mck_q     (mck_q),
   .mck_wrap  (mck_wrap),
   .mck_lim   (mck_lim),
   .mck_o     (mck_o)
);

// File: tb/tb_audclk_gen.sv
`timescale 1ns/1ps
module tb_audclk_gen;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       is_master = 1'b1;
   logic       clk_on = 1'b0;
   logic       clk_off = 1'b0;
   logic       mck_mode = 1'b1;
   logic [5:0] mck_div = '0;
   logic [5:0] fs_div = '0;
   logic       mck_o, bck_o, fs_o;
   logic       p_mck, p_bck, p_fs, n_mck, n_bck;
   int         total = 0;
   int         bad = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   audclk_gen dut (
      .src_clk(clk), .rst_n(rst_n), .is_master(is_master), .clk_on(clk_on),
      .clk_off(clk_off), .mck_mode(mck_mode), .mck_div(mck_div), .fs_div(fs_div),
      .mck_o(mck_o), .bck_o(bck_o), .fs_o(fs_o)
   );

   // {DIV, FS, expected master-clock edges per frame (0: not integral)}
   localparam int VT [0:6][0:2] = '{
      '{7, 63, 256}, '{0, 47, 1536}, '{7, 15, 64}, '{2, 3, 0},
      '{4, 1, 0},    '{1, 0, 16},    '{5, 2, 16}
   };
   localparam bit SEQ_R6 [0:7] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

   task automatic check(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!done) begin
         done = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   // One source cycle: sample after the rising edge, then after the falling edge.
   task automatic cyc();
      @(posedge clk); #2;
      p_mck = mck_o; p_bck = bck_o; p_fs = fs_o;
      @(negedge clk); #2;
      n_mck = mck_o; n_bck = bck_o;
   endtask

   task automatic start_gen(input bit mode, input int dv, input int f);
      mck_mode = mode; mck_div = 6'(dv); fs_div = 6'(f);
      clk_on = 1'b1;
      cyc();
      clk_on = 1'b0;
   endtask

   task automatic stop_gen();
      clk_off = 1'b1;
      cyc();
      clk_off = 1'b0;
      repeat (70) cyc();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check("WATCHDOG", 0, 1);
      report();
   end

   initial begin
      int errs;
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 reset mck", int'(mck_o), 0);
      check("R1 reset fs", int'(fs_o), 0);
      #1 rst_n = 1'b1;
      repeat (4) cyc();
      check("R1 idle outputs", int'({p_mck, p_bck, p_fs, n_mck, n_bck}), 0);

      // Ratio table walk: R2 R3 R4 R5
      for (int v = 0; v < 7; v++) begin
         int dv, f, n, h, per, em, ef, eb, rises;
         bit prevn, ep, en;
         dv = VT[v][0]; f = VT[v][1];
         n = dv + 1; h = (n + 1) / 2; per = 32 * (f + 1);
         em = 0; ef = 0; eb = 0; rises = 0; prevn = 1'b0;
         mck_mode = 1'b1; mck_div = 6'(dv); fs_div = 6'(f);
         clk_on = 1'b1;
         for (int k = 0; k < per; k++) begin
            cyc();
            clk_on = 1'b0;
            ep = (k % n) < h;
            en = (dv == 0) ? 1'b0 : ep;
            if (p_mck != ep || n_mck != en) em++;
            if (p_fs != ((k % per) < per / 2)) ef++;
            if (p_bck || n_bck) eb++;
            if (!prevn && p_mck) rises++;
            prevn = n_mck;
         end
         if (dv == 0) check("R3 bypass mismatches", em, 0);
         else         check("R2 divide mismatches", em, 0);
         check("R4 frame mismatches", ef, 0);
         check("R5 bck low in mode 1", eb, 0);
         if (VT[v][2] != 0) check("R4 edges per frame", rises, VT[v][2]);
         stop_gen();
         check("R7 idle after stop", int'({p_mck, n_mck, p_fs}), 0);
      end

      // R7: stop in high phase (DIV=5, high for cycles 0..2)
      start_gen(1'b1, 5, 0);
      clk_off = 1'b1;
      cyc();                       // k=1
      clk_off = 1'b0;
      check("R7 high phase kept k1", int'(p_mck), 1);
      cyc();                       // k=2
      check("R7 high phase kept k2", int'(p_mck), 1);
      errs = 0;
      for (int k = 3; k < 15; k++) begin
         cyc();
         if (p_mck || n_mck) errs++;
      end
      check("R7 low after high phase", errs, 0);

      // R7: stop in low phase, no new pulse at wrap
      start_gen(1'b1, 5, 0);
      repeat (3) cyc();            // k=1..3
      clk_off = 1'b1;
      cyc();                       // k=4
      clk_off = 1'b0;
      errs = 0;
      for (int k = 5; k < 16; k++) begin
         cyc();
         if (p_mck || n_mck || p_fs) errs++;
      end
      check("R7 no pulse after low stop", errs, 0);

      // R6 + R8: ratio change and start strobe mid-period
      start_gen(1'b1, 5, 0);
      cyc();                       // k=1
      mck_div = 6'd1; clk_on = 1'b1;
      errs = 0;
      for (int k = 2; k < 10; k++) begin
         cyc();
         clk_on = 1'b0;
         if (p_mck != SEQ_R6[k-2]) errs++;
      end
      check("R6 reload at wrap, R8 no restart", errs, 0);
      stop_gen();

      // R5 + R9: bit-clock pass mode
      start_gen(1'b0, 3, 0);
      check("R9 bck gate not yet open k0", int'(p_bck), 0);
      errs = 0;
      for (int k = 1; k < 8; k++) begin
         cyc();
         mck_mode = 1'b1;          // ignored while running
         if (p_bck != 1'b1 || n_bck != 1'b0 || p_mck || n_mck) errs++;
      end
      check("R5 bck follows source, mck low", errs, 0);
      clk_off = 1'b1;
      cyc();
      clk_off = 1'b0;
      check("R9 last bck pulse completes", int'(p_bck), 1);
      check("R9 bck low after pulse", int'(n_bck), 0);
      cyc();
      check("R9 bck stopped", int'({p_bck, n_bck}), 0);
      repeat (4) cyc();

      // R8: slave refuses start
      is_master = 1'b0;
      start_gen(1'b1, 2, 0);
      errs = 0;
      for (int k = 0; k < 6; k++) begin
         cyc();
         if (p_mck || n_mck || p_fs || p_bck) errs++;
      end
      check("R8 slave start ignored", errs, 0);
      is_master = 1'b1;

      // R8: stop wins over start in same cycle
      clk_off = 1'b1;
      start_gen(1'b1, 2, 0);
      clk_off = 1'b0;
      errs = 0;
      for (int k = 0; k < 6; k++) begin
         cyc();
         if (p_mck || n_mck || p_fs) errs++;
      end
      check("R8 stop wins", errs, 0);

      report();
   end
endmodule